// File: doc/BRIEF.md
# Beam Weight Store with Position Sequencer

This block holds the amplitude and phase weights for every channel of a beamformer and presents two active weight sets, one for transmit and one for receive, to the datapath. Weights can come from either of two sources. The first is a shadow register bank written by the host through a simple word write port. Shadow contents stay invisible until a load strobe copies them into the active set. The second is a position memory that stores many complete beam positions in advance. A pointer sequencer walks that memory between a programmable first and last position.

Stepping to the next stored position is a fixed-length fetch. An advance pulse starts it, and a load strobe then commits the fetched position to the active set selected by the mode input. A load that arrives while a fetch is still running is remembered and applied when the fetch ends. The fetch always runs its full length. The memory is split into equal partitions. The host may refill any partition except the one the pointer is currently in. A write aimed at that partition is dropped and reported.

Top module: `bw_store`

## Requirements
- R1: After reset both active weight outputs are zero, the pointer is at position 0, and `fetch_busy` and `wr_err` are low.
- R2: The active outputs change only on a load. Host writes to the shadow registers or to memory never alter them directly.
- R3: With `src_mem`=0, a `load` copies the shadow set chosen by `tx_mode` into the matching active set on the next clock edge. `tx_mode`=1 selects transmit and 0 selects receive. The other active set is left unchanged.
- R4: An `adv` pulse while idle raises `fetch_busy` for exactly FETCH_CYC (6) cycles. The pointer keeps its old value during that time and takes the new position on the edge where `fetch_busy` falls.
- R5: The new position is the `start_ptr` value if the pointer equals `stop_ptr`. Otherwise it is pointer+1, with position DEPTH-1 followed by 0.
- R6: With `src_mem`=1 and no fetch running, a `load` writes the memory contents at the current pointer into the active set chosen by `tx_mode` on the next edge.
- R7: A memory-source `load` during a fetch is held and applied on the edge that ends the fetch, using the `tx_mode` it arrived with. An `adv` during a fetch is ignored.
- R8: A memory write whose position lies in the same partition as the current pointer is discarded, and `wr_err` is high for the one cycle after it. A partition is a run of DEPTH/NPART consecutive positions; with the defaults these are 0-3 and 4-7. Writes to other partitions are stored, and `wr_err` stays low after them.
- R9: A word write targets one channel. `wr_ch` selects the channel, and channel c occupies bits [c*WW +: WW] of each weight output, with WW = AMP_W+PH_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host word write strobe |
| wr_mem | input | 1 | 1: write goes to position memory, 0: to shadow registers |
| wr_tx | input | 1 | Shadow write target set, 1 transmit / 0 receive |
| wr_ch | input | CH_W | Channel of the written word |
| wr_addr | input | PTR_W | Memory position of the written word |
| wr_data | input | WW | Weight word, amplitude in the upper AMP_W bits |
| src_mem | input | 1 | Load source, 1 memory / 0 shadow registers |
| tx_mode | input | 1 | Active set a load applies to, 1 transmit / 0 receive |
| load | input | 1 | Commit strobe |
| adv | input | 1 | Start fetch of next memory position |
| start_ptr | input | PTR_W | First position of the sequence |
| stop_ptr | input | PTR_W | Last position of the sequence |
| tx_weights | output | NCH*WW | Active transmit weights |
| rx_weights | output | NCH*WW | Active receive weights |
| pos_ptr | output | PTR_W | Current memory position |
| fetch_busy | output | 1 | Fetch in progress |
| wr_err | output | 1 | Rejected memory write, one-cycle pulse |

## Verification
The bench uses the default build: eight positions in two partitions, two channels and a six-cycle fetch. With only eight positions, a handful of advances is enough to wrap from stop to start, to wrap from the top of memory back to 0, and to move the pointer from one partition into the other. Both directions of the write-rejection rule are therefore exercised from short sequences. Two channels are enough to show that a word lands in the intended channel field and nowhere else.

// File: rtl/bw_pkg.sv
package bw_pkg;
  // next sequencer position: last -> first, top of memory -> 0
  function automatic int unsigned bw_next_pos(int unsigned cur, int unsigned first,
                                              int unsigned last, int unsigned depth);
    if (cur == last) return first;
    if (cur == depth - 1) return 0;
    return cur + 1;
  endfunction

  // partition index of a memory position
  function automatic int unsigned bw_part_of(int unsigned pos, int unsigned depth,
                                             int unsigned nparts);
    return pos / (depth / nparts);
  endfunction
endpackage

// File: rtl/bw_shadow.sv
module bw_shadow #(
  parameter int NCH  = 2,
  parameter int WW   = 11,
  parameter int CH_W = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_tx,
  input  logic [CH_W-1:0]     wr_ch,
  input  logic [WW-1:0]       wr_data,
  output logic [NCH*WW-1:0]   tx_sh,
  output logic [NCH*WW-1:0]   rx_sh
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wire hit = wr_en && (32'(wr_ch) == c);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tx_sh[c*WW +: WW] <= '0;
        rx_sh[c*WW +: WW] <= '0;
      end else if (hit) begin
        if (wr_tx) tx_sh[c*WW +: WW] <= wr_data;
        else       rx_sh[c*WW +: WW] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/bw_pos_mem.sv
module bw_pos_mem
  import bw_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NPART = 2,
  parameter int NCH   = 2,
  parameter int WW    = 11,
  parameter int PTR_W = 3,
  parameter int CH_W  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PTR_W-1:0]   wr_addr,
  input  logic [CH_W-1:0]    wr_ch,
  input  logic [WW-1:0]      wr_data,
  input  logic [PTR_W-1:0]   act_ptr,
  input  logic [PTR_W-1:0]   rd_addr,
  output logic [NCH*WW-1:0]  rd_data,
  output logic               wr_err
);
  logic [WW-1:0] mem_q [DEPTH][NCH];

  // write collides with the partition being read
  wire wr_hit = wr_en && (bw_part_of(32'(wr_addr), DEPTH, NPART) ==
                          bw_part_of(32'(act_ptr), DEPTH, NPART));
  wire wr_ok  = wr_en && !wr_hit;

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wr_addr][wr_ch] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= wr_hit;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_rd
    assign rd_data[c*WW +: WW] = mem_q[rd_addr][c];
  end

  p_reject_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> wr_err);
  p_quiet_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !wr_err);
endmodule

// File: rtl/bw_seq.sv
module bw_seq
  import bw_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int FETCH_CYC = 6,
  parameter int PTR_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             load,
  input  logic             tx_mode,
  input  logic [PTR_W-1:0] start_ptr,
  input  logic [PTR_W-1:0] stop_ptr,
  output logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] tgt,
  output logic             busy,
  output logic             fetch_done,
  output logic             held_apply,
  output logic             held_mode
);
  localparam int CNT_W = $clog2(FETCH_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] ptr_q, tgt_q;
  logic             pend_q, pmode_q;

  assign busy       = (cnt_q != '0);
  assign fetch_done = (cnt_q == CNT_W'(1));
  assign held_apply = fetch_done && (pend_q || load);
  assign held_mode  = load ? tx_mode : pmode_q;
  assign ptr        = ptr_q;
  assign tgt        = tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ptr_q   <= '0;
      tgt_q   <= '0;
      pend_q  <= 1'b0;
      pmode_q <= 1'b0;
    end else begin
      if (adv && !busy) begin
        cnt_q <= CNT_W'(FETCH_CYC);
        tgt_q <= PTR_W'(bw_next_pos(32'(ptr_q), 32'(start_ptr), 32'(stop_ptr), DEPTH));
      end else if (busy) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (fetch_done) begin
        ptr_q  <= tgt_q;
        pend_q <= 1'b0;
      end else if (load && busy) begin
        pend_q  <= 1'b1;
        pmode_q <= tx_mode;
      end
    end
  end

  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_done |=> $stable(ptr_q));
  p_wrap_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !busy && ptr_q == stop_ptr) |=> (tgt_q == $past(start_ptr)));
  p_hold_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && busy && !fetch_done) |=> pend_q);
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fetch_done) |=> busy);
endmodule

// File: rtl/bw_store.sv
module bw_store #(
  parameter int NCH       = 2,
  parameter int AMP_W     = 5,
  parameter int PH_W      = 6,
  parameter int DEPTH     = 8,
  parameter int NPART     = 2,
  parameter int FETCH_CYC = 6,
  parameter int WW        = AMP_W + PH_W,
  parameter int PTR_W     = $clog2(DEPTH),
  parameter int CH_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_mem,
  input  logic              wr_tx,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [WW-1:0]     wr_data,
  input  logic              src_mem,
  input  logic              tx_mode,
  input  logic              load,
  input  logic              adv,
  input  logic [PTR_W-1:0]  start_ptr,
  input  logic [PTR_W-1:0]  stop_ptr,
  output logic [NCH*WW-1:0] tx_weights,
  output logic [NCH*WW-1:0] rx_weights,
  output logic [PTR_W-1:0]  pos_ptr,
  output logic              fetch_busy,
  output logic              wr_err
);
  logic [NCH*WW-1:0] tx_sh, rx_sh, mem_rd;
  logic [NCH*WW-1:0] tx_q, rx_q;
  logic [PTR_W-1:0]  ptr, tgt;
  logic              busy, fetch_done, held_apply, held_mode;

  bw_shadow #(.NCH(NCH), .WW(WW), .CH_W(CH_W)) u_shadow (
    .clk, .rst_n, .wr_en(wr_en && !wr_mem), .wr_tx, .wr_ch, .wr_data,
    .tx_sh, .rx_sh);

  bw_seq #(.DEPTH(DEPTH), .FETCH_CYC(FETCH_CYC), .PTR_W(PTR_W)) u_seq (
    .clk, .rst_n, .adv, .load(load && src_mem), .tx_mode, .start_ptr, .stop_ptr,
    .ptr, .tgt, .busy, .fetch_done, .held_apply, .held_mode);

  bw_pos_mem #(.DEPTH(DEPTH), .NPART(NPART), .NCH(NCH), .WW(WW), .PTR_W(PTR_W),
               .CH_W(CH_W)) u_mem (
    .clk, .rst_n, .wr_en(wr_en && wr_mem), .wr_addr, .wr_ch, .wr_data,
    .act_ptr(ptr), .rd_addr(busy ? tgt : ptr), .rd_data(mem_rd), .wr_err);

  // commit events, brought out for the checks below
  wire reg_commit = load && !src_mem;
  wire mem_commit = src_mem && ((load && !busy) || held_apply);
  wire mem_to_tx  = busy ? held_mode : tx_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (reg_commit) begin
      if (tx_mode) tx_q <= tx_sh;
      else         rx_q <= rx_sh;
    end else if (mem_commit) begin
      if (mem_to_tx) tx_q <= mem_rd;
      else           rx_q <= mem_rd;
    end
  end

  assign tx_weights = tx_q;
  assign rx_weights = rx_q;
  assign pos_ptr    = ptr;
  assign fetch_busy = busy;

  p_active_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_commit || mem_commit) |=> ($stable(tx_weights) && $stable(rx_weights)));
  p_other_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_commit && tx_mode) |=> $stable(rx_weights));
  p_other_set_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_commit && !tx_mode) |=> $stable(tx_weights));
  p_ptr_partition_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(wr_en && wr_mem));
endmodule

// File: tb/bw_store_bench.sv
module bw_store_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2, WW = 11, PTR_W = 3, CH_W = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_mem = 0, wr_tx = 0, src_mem = 0, tx_mode = 0, load = 0, adv = 0;
  logic [CH_W-1:0]  wr_ch = '0;
  logic [PTR_W-1:0] wr_addr = '0, start_ptr = '0, stop_ptr = '0;
  logic [WW-1:0]    wr_data = '0;
  logic [NCH*WW-1:0] tx_weights, rx_weights;
  logic [PTR_W-1:0]  pos_ptr;
  logic              fetch_busy, wr_err;

  int n_run = 0, n_fail = 0;
  logic [WW-1:0] bmem [8][NCH];
  logic [NCH*WW-1:0] saved;

  // stepping table: {start, stop, expected new pointer, load tx_mode}
  localparam logic [9:0] STEPS [9] = '{
    {3'd4, 3'd6, 3'd5, 1'b1}, {3'd4, 3'd6, 3'd6, 1'b0}, {3'd4, 3'd6, 3'd4, 1'b1},
    {3'd6, 3'd1, 3'd5, 1'b0}, {3'd6, 3'd1, 3'd6, 1'b1}, {3'd6, 3'd1, 3'd7, 1'b0},
    {3'd6, 3'd1, 3'd0, 1'b1}, {3'd6, 3'd1, 3'd1, 1'b0}, {3'd6, 3'd1, 3'd6, 1'b1}};

  bw_store u_bw_store (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] pat(int pos, int ch);
    return WW'(pos * 37 + ch * 5 + 3);
  endfunction

  function automatic logic [NCH*WW-1:0] posword(int pos);
    return {bmem[pos][1], bmem[pos][0]};
  endfunction

  task automatic wr(input bit mem, input bit tx, input int ch, input int addr,
                    input logic [WW-1:0] d);
    wr_en = 1; wr_mem = mem; wr_tx = tx; wr_ch = CH_W'(ch); wr_addr = PTR_W'(addr);
    wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_load(input bit mem, input bit tx);
    load = 1; src_mem = mem; tx_mode = tx;
    @(negedge clk);
    load = 0;
  endtask

  task automatic advance(output int nbusy);
    adv = 1;
    @(negedge clk);
    adv = 0;
    nbusy = 0;
    while (fetch_busy && nbusy < 20) begin
      nbusy++;
      @(negedge clk);
    end
  endtask

  initial begin
    int nb;
    logic [NCH*WW-1:0] other;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(tx_weights == '0, "R1 tx", 64'(tx_weights), 0);
    check(rx_weights == '0, "R1 rx", 64'(rx_weights), 0);
    check(pos_ptr == 0, "R1 ptr", 64'(pos_ptr), 0);
    check(!fetch_busy && !wr_err, "R1 flags", {fetch_busy, wr_err}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 / R9: shadow writes invisible until load
    wr(0, 1, 0, 0, 11'h155); wr(0, 1, 1, 0, 11'h2AA);
    wr(0, 0, 0, 0, 11'h0F1); wr(0, 0, 1, 0, 11'h70E);
    check(tx_weights == '0 && rx_weights == '0, "R2 shadow", 64'(tx_weights), 0);
    do_load(0, 1);
    check(tx_weights == {11'h2AA, 11'h155}, "R3 tx load", 64'(tx_weights),
          64'({11'h2AA, 11'h155}));
    check(rx_weights == '0, "R3 rx untouched", 64'(rx_weights), 0);
    wr(0, 1, 0, 0, 11'h001);
    check(tx_weights == {11'h2AA, 11'h155}, "R2 rewrite", 64'(tx_weights),
          64'({11'h2AA, 11'h155}));
    do_load(0, 0);
    check(rx_weights == {11'h70E, 11'h0F1}, "R9 rx load chans", 64'(rx_weights),
          64'({11'h70E, 11'h0F1}));
    check(tx_weights == {11'h2AA, 11'h155}, "R3 tx untouched", 64'(tx_weights),
          64'({11'h2AA, 11'h155}));

    // R8: pointer at 0 (partition 0); fill partition 1
    for (int p = 4; p < 8; p++)
      for (int c = 0; c < NCH; c++) begin
        wr(1, 0, c, p, pat(p, c)); bmem[p][c] = pat(p, c);
      end
    check(!wr_err, "R8 accepted write", 64'(wr_err), 0);
    wr(1, 0, 0, 2, 11'h7FF);
    check(wr_err, "R8 reject flag", 64'(wr_err), 1);
    @(negedge clk);
    check(!wr_err, "R8 flag pulse", 64'(wr_err), 0);

    // R4/R5: stop==pointer jumps to start
    start_ptr = 3'd4; stop_ptr = 3'd0;
    advance(nb);
    check(nb == 6, "R4 busy length", 64'(nb), 6);
    check(pos_ptr == 4, "R5 stop->start", 64'(pos_ptr), 4);

    // now partition 1 active: fill partition 0, reject a write to 5
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < NCH; c++) begin
        wr(1, 0, c, p, pat(p, c)); bmem[p][c] = pat(p, c);
      end
    wr(1, 0, 1, 5, 11'h7FF);
    check(wr_err, "R8 reject part1", 64'(wr_err), 1);

    // table walk: R5 ordering, R6 idle memory load
    for (int i = 0; i < 9; i++) begin
      start_ptr = STEPS[i][9:7]; stop_ptr = STEPS[i][6:4];
      advance(nb);
      check(pos_ptr == STEPS[i][3:1], "R5 step", 64'(pos_ptr), 64'(STEPS[i][3:1]));
      other = STEPS[i][0] ? rx_weights : tx_weights;
      do_load(1, STEPS[i][0]);
      if (STEPS[i][0])
        check(tx_weights == posword(STEPS[i][3:1]) && rx_weights == other,
              "R6 tx mem load", 64'(tx_weights), 64'(posword(STEPS[i][3:1])));
      else
        check(rx_weights == posword(STEPS[i][3:1]) && tx_weights == other,
              "R6 rx mem load", 64'(rx_weights), 64'(posword(STEPS[i][3:1])));
    end

    // R7: load and advance during fetch (pointer at 6, stop 1 -> 7)
    adv = 1; @(negedge clk); adv = 0;
    saved = rx_weights;
    load = 1; src_mem = 1; tx_mode = 0; @(negedge clk); load = 0; tx_mode = 1;
    adv = 1; @(negedge clk); adv = 0;
    check(rx_weights == saved, "R7 held not early", 64'(rx_weights), 64'(saved));
    @(negedge clk); @(negedge clk); @(negedge clk);
    check(fetch_busy && rx_weights == saved, "R7 fetch full length",
          {fetch_busy, 22'(rx_weights)}, {1'b1, 22'(saved)});
    @(negedge clk);
    check(!fetch_busy, "R7 fetch end", 64'(fetch_busy), 0);
    check(pos_ptr == 7, "R7 single step", 64'(pos_ptr), 7);
    check(rx_weights == posword(7), "R7 held applied", 64'(rx_weights), 64'(posword(7)));
    @(negedge clk);
    check(!fetch_busy, "R7 adv ignored", 64'(fetch_busy), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule